// File: doc/BRIEF.md
# Two-Stage Accumulator Core with Exposed Branch Slot

This block is a compact 8-bit accumulator processor. Each cycle it executes the 16-bit instruction word held in its instruction and operand registers while it fetches the next word from a program ROM. Because of this overlap, a branch redirects fetching only after the word behind it has already been fetched. That word, the delay slot, always executes. Software is expected to fill the slot with useful work. The slot may even hold another branch, which gives single-instruction table lookups and balanced two-way selects.

An instruction word carries an 8-bit opcode in its upper byte and an 8-bit operand byte in its lower byte. Opcode bits 7:5 pick the operation (000 load, 100 add, 101 subtract, 110 store, 111 branch). Bits 4:2 pick a load variant or a branch condition mask. Bits 1:0 pick the value source (00 operand byte, 01 RAM at the operand address, 10 accumulator). Data memory is a byte RAM addressed by the operand byte, with a combinational read path. The accumulator and the fetch address are brought out for observation.

Top module: `acc_core`

## Requirements
- R1: While reset is active and after it is released, the fetch address, accumulator and output register start at zero and no RAM write occurs. The first executed slot after reset behaves as a no-operation (instruction register 0x02).
- R2: Opcode 0x00 loads the operand byte into the accumulator, 0x01 loads RAM[operand], and 0x02 reloads the accumulator with itself, leaving it unchanged.
- R3: Opcode 0x81 adds RAM[operand] to the accumulator and 0xA0 subtracts the operand byte, both modulo 256.
- R4: Opcode 0xC2 writes the accumulator to RAM[operand], and the accumulator keeps its value. The RAM write strobe is high only while a store executes.
- R5: Opcode 0x1A loads the accumulator from itself and also copies it into the output register. No other instruction changes the output register.
- R6: Without a branch, fetching advances by one word per cycle. A taken branch changes the fetch address one cycle late, so the word right after any branch always executes.
- R7: Branch opcodes 0xFC (always), 0xEC (accumulator non-zero), 0xF4 (accumulator signed value >= 0) and 0xF0 (accumulator zero) test the accumulator value present while the branch executes, before its delay-slot word changes it.
- R8: Opcode 0xFE branches to the address given by the accumulator.
- R9: A taken branch replaces only the low byte of the fetch address and keeps the current 256-word page. Sequential fetching carries into the next page.
- R10: With a branch in the delay slot of another taken branch, exactly one word runs at the first target, and execution then continues at the second target.
- R11: The sequence load 5, branch-if-non-zero to itself, subtract 1 runs 13 cycles from the load to the exit, leaving the accumulator at 0xFF.
- R12: The sequence load [C], branch-if-zero +3, branch +3, load [A], load [B], store [V] takes five cycles on both paths. It stores B when C is zero and A otherwise, including when C is negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rom_addr | output | 16 | Program ROM word address being fetched |
| rom_data | input | 16 | Program ROM word at rom_addr |
| ram_addr | output | 8 | Data RAM byte address (operand byte) |
| ram_rdata | input | 8 | Data RAM read value at ram_addr |
| ram_wdata | output | 8 | Data RAM write value |
| ram_we | output | 1 | Data RAM write strobe |
| out_reg | output | 8 | Output register |
| ac_obs | output | 8 | Accumulator value |
| pc_obs | output | 16 | Fetch address register |

## Verification
In the cycle that executes a branch's delay-slot word, the core also applies that branch's redirect to the fetch address. When the slot word is itself a taken branch, a second redirect is decided in the very next cycle. These cycles are provoked by programs run from a bench ROM: a self-targeted countdown whose slot decrements the accumulator the branch just tested, a branch-to-accumulator table lookup whose slot returns, and a select whose two branches sit back to back. The results are judged by the values written to RAM and the output register. They are also judged by the cycle spacing between consecutive stores or output changes, which exposes a lost or extra slot.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OPW = 8;

  localparam logic [2:0] OPF_LD  = 3'b000;
  localparam logic [2:0] OPF_ADD = 3'b100;
  localparam logic [2:0] OPF_SUB = 3'b101;
  localparam logic [2:0] OPF_ST  = 3'b110;
  localparam logic [2:0] OPF_BR  = 3'b111;

  localparam logic [2:0] LDV_TO_OUT = 3'b110;
  localparam logic [OPW-1:0] OPC_IDLE = 8'h02;

  typedef enum logic [1:0] {
    SRC_OPND = 2'b00,
    SRC_MEM  = 2'b01,
    SRC_ACC  = 2'b10,
    SRC_RSV  = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_KEEP
  } alu_e;

  typedef struct packed {
    alu_e       alu;
    src_e       src;
    logic [2:0] cmask;
    logic       ac_en;
    logic       out_en;
    logic       mem_we;
    logic       is_br;
  } ctrl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_core_pkg::*;
(
  input  logic [OPW-1:0] opc,
  output ctrl_t          ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu    = ALU_KEEP;
    ctrl.src    = src_e'(opc[1:0]);
    ctrl.cmask  = opc[4:2];
    unique case (opc[7:5])
      OPF_LD: begin
        ctrl.alu    = ALU_PASS;
        ctrl.ac_en  = 1'b1;
        ctrl.out_en = (opc[4:2] == LDV_TO_OUT);
      end
      OPF_ADD: begin
        ctrl.alu   = ALU_ADD;
        ctrl.ac_en = 1'b1;
      end
      OPF_SUB: begin
        ctrl.alu   = ALU_SUB;
        ctrl.ac_en = 1'b1;
      end
      OPF_ST:  ctrl.mem_we = 1'b1;
      OPF_BR:  ctrl.is_br  = 1'b1;
      default: ctrl.alu    = ALU_KEEP;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_e          op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_PASS: y = b;
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      default:  y = a;
    endcase
  end

endmodule

// File: rtl/acc_branch.sv
module acc_branch #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          is_br,
  input  logic [2:0]    cmask,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] target,
  input  logic [AW-1:0] pc,
  output logic          taken,
  output logic [AW-1:0] pc_nxt
);

  localparam int PAGE_W = AW - DW;

  logic [2:0] flag;
  logic [2:0] hit;
  logic       acc_zero;

  assign acc_zero = (acc == '0);
  assign flag[0]  = !acc[DW-1] && !acc_zero;
  assign flag[1]  = acc[DW-1];
  assign flag[2]  = acc_zero;

  for (genvar i = 0; i < 3; i++) begin : g_cond
    assign hit[i] = cmask[i] & flag[i];
  end

  assign taken = is_br & (|hit);

  always_comb begin
    if (taken) pc_nxt = {pc[AW-1 -: PAGE_W], target};
    else       pc_nxt = pc + AW'(1);
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [AW-1:0]     rom_addr,
  input  logic [OPW+DW-1:0] rom_data,
  output logic [DW-1:0]     ram_addr,
  input  logic [DW-1:0]     ram_rdata,
  output logic [DW-1:0]     ram_wdata,
  output logic              ram_we,
  output logic [DW-1:0]     out_reg,
  output logic [DW-1:0]     ac_obs,
  output logic [AW-1:0]     pc_obs
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rsync_q;
  logic              rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_core_n = rsync_q[SYNC_N-1];

  logic [AW-1:0]  pc_q, pc_d;
  logic [OPW-1:0] ir_q;
  logic [DW-1:0]  d_q;
  logic [DW-1:0]  ac_q, ac_d;
  logic [DW-1:0]  out_q;
  logic [DW-1:0]  bus;
  logic           br_taken;
  ctrl_t          ctrl;

  acc_decode u_dec (
    .opc  (ir_q),
    .ctrl (ctrl)
  );

  always_comb begin
    unique case (ctrl.src)
      SRC_MEM: bus = ram_rdata;
      SRC_ACC: bus = ac_q;
      default: bus = d_q;
    endcase
  end

  acc_alu #(.DW(DW)) u_alu (
    .op (ctrl.alu),
    .a  (ac_q),
    .b  (bus),
    .y  (ac_d)
  );

  acc_branch #(.DW(DW), .AW(AW)) u_br (
    .is_br  (ctrl.is_br),
    .cmask  (ctrl.cmask),
    .acc    (ac_q),
    .target (bus),
    .pc     (pc_q),
    .taken  (br_taken),
    .pc_nxt (pc_d)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q <= '0;
      ir_q <= OPC_IDLE;
      d_q  <= '0;
    end else begin
      pc_q <= pc_d;
      ir_q <= rom_data[OPW+DW-1 -: OPW];
      d_q  <= rom_data[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)    ac_q <= '0;
    else if (ctrl.ac_en) ac_q <= ac_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)     out_q <= '0;
    else if (ctrl.out_en) out_q <= ac_d;
  end

  assign rom_addr  = pc_q;
  assign ram_addr  = d_q;
  assign ram_wdata = bus;
  assign ram_we    = ctrl.mem_we;
  assign out_reg   = out_q;
  assign ac_obs    = ac_q;
  assign pc_obs    = pc_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    ir_q,
  input logic [DW-1:0] d_q,
  input logic [AW-1:0] pc_q,
  input logic [DW-1:0] ac_q,
  input logic [DW-1:0] out_q,
  input logic          ram_we,
  input logic [DW-1:0] ram_wdata
);

  AST_STORE_KEEPS_AC: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> ac_q == $past(ac_q)); // R4

  AST_STORE_DATA_AC: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ir_q[1:0] == 2'b10) |-> ram_wdata == ac_q); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[7:2] != 6'b000110) |=> out_q == $past(out_q)); // R5

  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[7:5] != 3'b111) |=> pc_q == $past(pc_q) + 1'b1); // R6

  AST_BRA_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q == 8'hFC) |=> pc_q[DW-1:0] == $past(d_q)); // R6

  AST_BNE_ZERO_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q == 8'hEC && ac_q == '0) |=> pc_q == $past(pc_q) + 1'b1); // R7

  AST_BRA_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q == 8'hFE) |=> pc_q[DW-1:0] == $past(ac_q)); // R8

  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[7:5] == 3'b111 && pc_q[DW-1:0] != '1)
      |=> pc_q[AW-1:DW] == $past(pc_q[AW-1:DW])); // R9

endmodule

bind acc_core acc_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .ir_q      (ir_q),
  .d_q       (d_q),
  .pc_q      (pc_q),
  .ac_q      (ac_q),
  .out_q     (out_q),
  .ram_we    (ram_we),
  .ram_wdata (ram_wdata)
);

// File: tb/sim_acc_core.sv
module sim_acc_core;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rom_addr;
  logic [15:0]   rom_data;
  logic [DW-1:0] ram_addr, ram_rdata, ram_wdata;
  logic          ram_we;
  logic [DW-1:0] out_reg, ac_obs;
  logic [AW-1:0] pc_obs;

  logic [15:0]   rom [0:511];
  logic [7:0]    ram [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .out_reg(out_reg), .ac_obs(ac_obs), .pc_obs(pc_obs)
  );

  assign rom_data  = rom[rom_addr[8:0]];
  assign ram_rdata = ram[ram_addr];

  always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         kind;
    logic [7:0] addr;
    logic [7:0] data;
    int         delta;
    string      tag;
  } item_t;

  item_t      exp_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         track_st = 1'b1;
  int         last_st = 0;
  int         last_out = 0;
  logic [7:0] out_prev = '0;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(int kind, logic [7:0] a, logic [7:0] v, int dl, string tag);
    item_t it;
    it.kind = kind; it.addr = a; it.data = v; it.delta = dl; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic score(int kind, logic [7:0] a, logic [7:0] v, int dl);
    item_t it;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R6 unexpected event kind=%0d actual addr=%h data=%h expected none",
               kind, a, v);
    end else begin
      it = exp_q.pop_front();
      if (it.kind != kind || it.addr != a || it.data != v ||
          (it.delta >= 0 && it.delta != dl)) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual addr=%h data=%h delta=%0d expected kind=%0d addr=%h data=%h delta=%0d",
                 it.tag, kind, a, v, dl, it.kind, it.addr, it.data, it.delta);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      out_prev = out_reg;
    end else begin
      if (track_st && ram_we) begin
        score(0, ram_addr, ram_wdata, cyc - last_st);
        last_st = cyc;
      end
      if (out_reg !== out_prev) begin
        score(1, 8'h00, out_reg, cyc - last_out);
        last_out = cyc;
        out_prev = out_reg;
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) rom[i] = 16'h0200;
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
  endtask

  task automatic run(int ncyc);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pc_obs == '0,  "R1", "reset pc",   pc_obs,  0);
    check(ac_obs == '0,  "R1", "reset ac",   ac_obs,  0);
    check(out_reg == '0, "R1", "reset out",  out_reg, 0);
    check(ram_we == 1'b0, "R1", "reset we",  ram_we,  0);
    rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
    check(exp_q.size() == 0, "R6", "events missing", exp_q.size(), 0);
    exp_q.delete();
  endtask

  function automatic logic [7:0] tbl(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // Countdown loop: R11 timing and exit value, R7 test before slot update
    clear_mem();
    rom[0] = 16'hC210; rom[1] = 16'h0005; rom[2] = 16'hEC02;
    rom[3] = 16'hA001; rom[4] = 16'hC211; rom[5] = 16'hFC05; rom[6] = 16'h0200;
    push(0, 8'h10, 8'h00, -1, "R1");
    push(0, 8'h11, 8'hFF, 14, "R11");
    run(60);
    check(ac_obs == 8'hFF, "R11", "loop exit ac", ac_obs, 8'hFF);

    // Back-to-back branches select: R12 and R6
    for (int k = 0; k < 3; k++) begin
      logic [7:0] cval, vexp;
      cval = (k == 0) ? 8'h00 : (k == 1) ? 8'h07 : 8'h80;
      vexp = (k == 0) ? 8'hA5 : 8'h5A;
      clear_mem();
      ram[8'h20] = cval; ram[8'h21] = 8'h5A; ram[8'h22] = 8'hA5;
      rom[0] = 16'hC230; rom[1] = 16'h0120; rom[2] = 16'hF005; rom[3] = 16'hFC06;
      rom[4] = 16'h0121; rom[5] = 16'h0122; rom[6] = 16'hC231;
      rom[7] = 16'hFC07; rom[8] = 16'h0200;
      push(0, 8'h30, 8'h00, -1, "R12");
      push(0, 8'h31, vexp, 5, (k == 1) ? "R6" : "R12");
      run(40);
      check(ac_obs == vexp, "R12", "select ac", ac_obs, vexp);
    end

    // Lookup via branch to accumulator with a return in its slot: R8 R9 R10
    for (int k = 0; k < 3; k++) begin
      int s;
      s = (k == 0) ? 0 : (k == 1) ? 5 : 15;
      clear_mem();
      ram[8'h41] = 8'(s);
      rom[9'h000] = 16'hFCFD; rom[9'h001] = 16'h0200;
      rom[9'h0FD] = 16'hC240; rom[9'h0FE] = 16'h0009; rom[9'h0FF] = 16'h8141;
      rom[9'h100] = 16'hFE00; rom[9'h101] = 16'hFC19;
      for (int i = 0; i < 16; i++) rom[9'h109 + i] = {8'h00, tbl(i)};
      rom[9'h119] = 16'hC242; rom[9'h11A] = 16'hFC1A; rom[9'h11B] = 16'h0200;
      push(0, 8'h40, 8'h00, -1, "R9");
      push(0, 8'h42, tbl(s), 6, (k == 0) ? "R8" : "R10");
      run(50);
      check(pc_obs[15:8] == 8'h01, "R9", "page kept", pc_obs[15:8], 8'h01);
    end

    // Arithmetic, store and output register: R2 R3 R4 R5
    clear_mem();
    ram[8'h60] = 8'h90; ram[8'h61] = 8'h85;
    rom[0] = 16'h007F; rom[1] = 16'hC250; rom[2] = 16'h0160; rom[3] = 16'hC251;
    rom[4] = 16'h8161; rom[5] = 16'hC252; rom[6] = 16'hA020; rom[7] = 16'hC253;
    rom[8] = 16'h0200; rom[9] = 16'hC254; rom[10] = 16'h1A00; rom[11] = 16'h0000;
    rom[12] = 16'hC255; rom[13] = 16'hFC0D; rom[14] = 16'h0200;
    push(0, 8'h50, 8'h7F, -1, "R2");
    push(0, 8'h51, 8'h90, 2, "R2");
    push(0, 8'h52, 8'h15, 2, "R3");
    push(0, 8'h53, 8'hF5, 2, "R3");
    push(0, 8'h54, 8'hF5, 2, "R2");
    push(1, 8'h00, 8'hF5, -1, "R4");
    push(0, 8'h55, 8'h00, 3, "R2");
    run(40);
    check(out_reg == 8'hF5, "R5", "out held", out_reg, 8'hF5);
    check(ac_obs == 8'h00, "R2", "final ac", ac_obs, 8'h00);

    // Number series with signed exit test: R7 and R5
    clear_mem();
    rom[0] = 16'h0000; rom[1] = 16'hC270; rom[2] = 16'h0001; rom[3] = 16'hC271;
    rom[4] = 16'h1A00; rom[5] = 16'h0170; rom[6] = 16'hC272; rom[7] = 16'h0171;
    rom[8] = 16'hC270; rom[9] = 16'h8172; rom[10] = 16'hC271; rom[11] = 16'hF404;
    rom[12] = 16'h0200; rom[13] = 16'hFC00; rom[14] = 16'h0200;
    track_st = 1'b0;
    push(1, 8'h00, 8'd1, -1, "R5");
    push(1, 8'h00, 8'd2, 18, "R7");
    push(1, 8'h00, 8'd3, 9, "R7");
    push(1, 8'h00, 8'd5, 9, "R7");
    push(1, 8'h00, 8'd8, 9, "R7");
    push(1, 8'h00, 8'd13, 9, "R7");
    push(1, 8'h00, 8'd21, 9, "R7");
    push(1, 8'h00, 8'd34, 9, "R7");
    push(1, 8'h00, 8'd55, 9, "R7");
    push(1, 8'h00, 8'd89, 9, "R7");
    push(1, 8'h00, 8'd1, 15, "R7");
    push(1, 8'h00, 8'd2, 18, "R7");
    run(135);

    summary();
    $finish;
  end

endmodule